// File: doc/BRIEF.md
# Dual-Mode Branch Metric Unit

This block produces the branch values for one trellis step of a rate-1/2 code. It takes a soft systematic sample, a soft parity sample and an a priori log-likelihood value, all 8-bit two's complement. A per-symbol mode select chooses between two uses of one shared datapath.

In hard-decision (Viterbi) mode, each soft sample is reduced to one bit from its sign. The block then reports the Hamming distance from the received bit pair to each of the four possible code pairs. In Log-MAP (turbo) mode, the block forms eight branch values. Each value combines the a priori term, signed by the hypothesised information bit, with the channel correlation of both samples against the hypothesised ±1 code symbols. The channel reliability is a power of two.

All branch values are registered and appear one cycle after the accepted symbol. They are meant to feed the state-metric processors directly. Routing them and storing them are done elsewhere.

Top module: `bmu_dual`

## Requirements
- R1: While `rstN` is low, and after it rises until the first accepted symbol, `outValid` is 0 and every slot of `metricsOut` is 0.
- R2: `outValid` is high in the cycle after a clock edge that sampled `inValid` high, and low in the cycle after one that sampled it low.
- R3: A clock edge with `inValid` low leaves every slot of `metricsOut` unchanged, whatever the other inputs are.
- R4: In Viterbi mode (`turboMode` = 0) a soft sample whose sign bit (bit 7) is clear is taken as code bit 1, and a sample whose sign bit is set is taken as code bit 0. A zero sample therefore decides to 1.
- R5: In Viterbi mode, slot j (j = 0..3) holds the Hamming distance, from 0 to 2, between the hard-decided pair and the hypothesis whose systematic bit is bit 1 of j and whose parity bit is bit 0 of j.
- R6: In Viterbi mode, slots 4 to 7 are 0.
- R7: In turbo mode, slot i is indexed as follows. Bit 2 of i is the information bit u, bit 1 is the systematic code bit, and bit 0 is the parity code bit. A hypothesised bit of 1 stands for symbol +1 and a bit of 0 stands for symbol −1.
- R8: In turbo mode, slot i equals su·apr + 2^LC_SHIFT·(ss·sys + sp·par), where su, ss and sp are the ±1 symbols of R7. This is twice the branch metric for a channel reliability of 2^LC_SHIFT, so one fraction bit is kept. The default LC_SHIFT is 1.
- R9: Full-scale inputs (−128 and +127 on every input) give exact results with no wrap, in signed slots of width 8+3+LC_SHIFT bits.
- R10: The mode is taken per symbol. Back-to-back symbols of different modes each produce the results of their own mode.
- R11: Slot i occupies bits [i·MW +: MW] of `metricsOut`, where MW = 8+3+LC_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Symbol present on the data inputs |
| turboMode | input | 1 | 1: Log-MAP branch values, 0: Hamming distances |
| sysIn | input | 8 | Soft systematic sample, signed |
| parIn | input | 8 | Soft parity sample, signed |
| aprIn | input | 8 | A priori LLR, signed |
| outValid | output | 1 | Branch values updated from the previous cycle's symbol |
| metricsOut | output | 8×MW (96) | Eight signed branch slots, slot i at bits i·MW |

## Verification
The hardest conditions to reach are the exact arithmetic corners. One is a zero sample, which sits on the hard-decision boundary. Another is three full-scale negative inputs, whose sum is the largest in magnitude the slot must hold without wrapping. The bench sweeps a value set that includes −128, −1, 0, 1 and 127 for each input, so that every combination of these edges appears in both modes. It then alternates modes on consecutive symbols with identical data, and feeds invalid cycles carrying changed data so that a missed hold shows up at the outputs.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;
  // Rate-1/2 trellis: four code-pair hypotheses, doubled by the info-bit sign
  localparam int NUM_PAIRS = 4;
  localparam int NUM_CASES = 2 * NUM_PAIRS;

  typedef struct packed {
    logic load;      // capture a new set of branch values
    logic selTurbo;  // pick Log-MAP values over Hamming distances
  } bmuStrobes_t;
endpackage

// File: rtl/bmu_ctrl.sv
`timescale 1ns/1ps
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        turboMode,
  output bmuStrobes_t strobes,
  output logic        outValid
);
  always_comb begin
    strobes.load     = inValid;
    strobes.selTurbo = turboMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/bmu_datapath.sv
`timescale 1ns/1ps
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int LC_SHIFT = 1,
  localparam int MW      = IN_W + 3 + LC_SHIFT
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bmuStrobes_t               strobes,
  input  logic [IN_W-1:0]           sysIn,
  input  logic [IN_W-1:0]           parIn,
  input  logic [IN_W-1:0]           aprIn,
  output logic [NUM_CASES*MW-1:0]   metricsOut
);
  localparam int EXT_W = MW - IN_W;

  logic signed [MW-1:0] sysExt, parExt, aprExt;
  logic                 hardSys, hardPar;

  always_comb begin
    sysExt  = {{EXT_W{sysIn[IN_W-1]}}, sysIn};
    parExt  = {{EXT_W{parIn[IN_W-1]}}, parIn};
    aprExt  = {{EXT_W{aprIn[IN_W-1]}}, aprIn};
    // non-negative sample decides to bit 1
    hardSys = ~sysIn[IN_W-1];
    hardPar = ~parIn[IN_W-1];
  end

  for (genvar i = 0; i < NUM_CASES; i++) begin : gCase
    localparam logic HYP_U = 1'((i >> 2) & 1);
    localparam logic HYP_S = 1'((i >> 1) & 1);
    localparam logic HYP_P = 1'(i & 1);

    logic signed [MW-1:0] aprTerm, sysTerm, parTerm, chanSum, turboVal;
    logic        [MW-1:0] vitVal;
    logic        [1:0]    hamDist;
    logic        [MW-1:0] slotQ;

    always_comb begin
      // +-1 products realised as add or subtract
      aprTerm  = HYP_U ? aprExt : -aprExt;
      sysTerm  = HYP_S ? sysExt : -sysExt;
      parTerm  = HYP_P ? parExt : -parExt;
      chanSum  = sysTerm + parTerm;
      turboVal = aprTerm + (chanSum <<< LC_SHIFT);
      hamDist  = {1'b0, hardSys ^ HYP_S} + {1'b0, hardPar ^ HYP_P};
      if (i < NUM_PAIRS) vitVal = {{(MW-2){1'b0}}, hamDist};
      else               vitVal = '0;
    end

    always_ff @(posedge clk) begin
      if (!rstN)             slotQ <= '0;
      else if (strobes.load) slotQ <= strobes.selTurbo ? turboVal : vitVal;
    end

    assign metricsOut[i*MW +: MW] = slotQ;
  end
endmodule

// File: rtl/bmu_dual.sv
`timescale 1ns/1ps
module bmu_dual
  import bmu_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int LC_SHIFT = 1,
  localparam int MW      = IN_W + 3 + LC_SHIFT
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic                    turboMode,
  input  logic [IN_W-1:0]         sysIn,
  input  logic [IN_W-1:0]         parIn,
  input  logic [IN_W-1:0]         aprIn,
  output logic                    outValid,
  output logic [NUM_CASES*MW-1:0] metricsOut
);
  bmuStrobes_t strobes;

  bmu_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .turboMode (turboMode),
    .strobes   (strobes),
    .outValid  (outValid)
  );

  bmu_datapath #(.IN_W(IN_W), .LC_SHIFT(LC_SHIFT)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .sysIn      (sysIn),
    .parIn      (parIn),
    .aprIn      (aprIn),
    .metricsOut (metricsOut)
  );
endmodule

// File: rtl/bmu_dual_chk.sv
`timescale 1ns/1ps
module bmu_dual_chk
  import bmu_pkg::*;
#(
  parameter int IN_W     = 8,
  parameter int LC_SHIFT = 1,
  localparam int MW      = IN_W + 3 + LC_SHIFT
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    turboMode,
  input logic [IN_W-1:0]         sysIn,
  input logic [IN_W-1:0]         parIn,
  input logic [IN_W-1:0]         aprIn,
  input logic                    outValid,
  input logic [NUM_CASES*MW-1:0] metricsOut
);
  logic signed [MW-1:0] slot [NUM_CASES];
  logic signed [MW-1:0] aprWide;

  for (genvar i = 0; i < NUM_CASES; i++) begin : gSlot
    assign slot[i] = metricsOut[i*MW +: MW];
  end
  assign aprWide = {{(MW-IN_W){aprIn[IN_W-1]}}, aprIn};

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(metricsOut));
  // R6
  vit_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !turboMode) |=>
      (slot[4] == 0 && slot[5] == 0 && slot[6] == 0 && slot[7] == 0));
  // R5
  vit_complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !turboMode) |=>
      (slot[0] + slot[3] == 2 && slot[1] + slot[2] == 2));
  // R4
  vit_hard_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !turboMode && !sysIn[IN_W-1] && !parIn[IN_W-1]) |=> slot[3] == 0);
  // R8
  turbo_antisym_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && turboMode) |=>
      (slot[0] + slot[7] == 0 && slot[1] + slot[6] == 0 &&
       slot[2] + slot[5] == 0 && slot[3] + slot[4] == 0));
  // R7
  turbo_apr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && turboMode) |=> (slot[4] - slot[0] == ($past(aprWide) <<< 1)));
endmodule

bind bmu_dual bmu_dual_chk #(.IN_W(IN_W), .LC_SHIFT(LC_SHIFT)) uChk (.*);

// File: tb/tb_bmu_dual.sv
`timescale 1ns/1ps
module tb_bmu_dual;
  localparam int IN_W = 8;
  localparam int LC   = 1;
  localparam int MW   = IN_W + 3 + LC;
  localparam int NC   = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               turboMode = 1'b0;
  logic [IN_W-1:0]    sysIn = '0, parIn = '0, aprIn = '0;
  logic               outValid;
  logic [NC*MW-1:0]   metricsOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  int lastExp [NC];

  always #2.5 clk = ~clk;

  bmu_dual #(.IN_W(IN_W), .LC_SHIFT(LC)) dut (.*);

  function automatic int expSlot(int s, int p, int a, bit turbo, int idx);
    int u  = (idx >> 2) & 1;
    int cs = (idx >> 1) & 1;
    int cp = idx & 1;
    if (turbo)
      return (u ? a : -a) + ((cs ? s : -s) + (cp ? p : -p)) * (1 << LC);
    if (idx >= 4) return 0;
    return (((s >= 0) ? 1 : 0) != cs ? 1 : 0) + (((p >= 0) ? 1 : 0) != cp ? 1 : 0);
  endfunction

  function automatic int slotVal(int idx);
    logic signed [MW-1:0] v;
    v = metricsOut[idx*MW +: MW];
    return int'(v);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // drive at a falling edge, inspect at the next falling edge
  task automatic sendSym(int s, int p, int a, bit turbo, string tag);
    sysIn = s[IN_W-1:0]; parIn = p[IN_W-1:0]; aprIn = a[IN_W-1:0];
    turboMode = turbo; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b1, "R2", "outValid", int'(outValid), 1);
    for (int i = 0; i < NC; i++) begin
      lastExp[i] = expSlot(s, p, a, turbo, i);
      check(slotVal(i) == lastExp[i], tag, $sformatf("slot%0d", i), slotVal(i), lastExp[i]);
    end
  endtask

  initial begin
    int vals [7] = '{-128, -77, -1, 0, 1, 50, 127};
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    for (int i = 0; i < NC; i++)
      check(slotVal(i) == 0, "R1", $sformatf("slot%0d in reset", i), slotVal(i), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid idle", int'(outValid), 0);

    // R4 R5 R6 R11: Viterbi sweep
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        sendSym(vals[a], vals[b], vals[(a + b) % 7], 1'b0, "R5");

    // R7 R8 R11: turbo sweep
    for (int a = 0; a < 7; a++)
      for (int b = 0; b < 7; b++)
        for (int c = 0; c < 7; c++)
          sendSym(vals[a], vals[b], vals[c], 1'b1, "R8");

    // R9: full-scale corners
    sendSym(-128, -128, -128, 1'b1, "R9");
    sendSym(127, 127, 127, 1'b1, "R9");
    sendSym(-128, -128, 127, 1'b1, "R9");
    sendSym(127, -128, -128, 1'b1, "R9");

    // R4: zero and minus one on the decision boundary
    sendSym(0, -1, 5, 1'b0, "R4");
    sendSym(-1, 0, 5, 1'b0, "R4");

    // R3: invalid cycles with changed data leave outputs alone
    for (int k = 0; k < 3; k++) begin
      sysIn = 8'h55; parIn = 8'hA3; aprIn = 8'h81; turboMode = k[0]; inValid = 1'b0;
      @(negedge clk);
      check(outValid == 1'b0, "R2", "outValid idle", int'(outValid), 0);
      for (int i = 0; i < NC; i++)
        check(slotVal(i) == lastExp[i], "R3", $sformatf("slot%0d held", i), slotVal(i), lastExp[i]);
    end

    // R10: per-symbol mode change, back to back
    for (int k = 0; k < 4; k++) begin
      sysIn = 8'(-20); parIn = 8'd33; aprIn = 8'(-9); turboMode = k[0]; inValid = 1'b1;
      @(negedge clk);
      for (int i = 0; i < NC; i++)
        check(slotVal(i) == expSlot(-20, 33, -9, k[0], i), "R10",
              $sformatf("slot%0d mode%0d", i, k[0]), slotVal(i), expSlot(-20, 33, -9, k[0], i));
    end
    inValid = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule